// File: doc/BRIEF.md
# Instrument Status Reporting Controller

This block keeps the two-level status structure of a bus-controlled instrument. Event strobes land in a sticky event register. Each bit of that register can be passed upward by an event enable mask, and the result forms one summary bit in the status byte. The status byte also carries a message-available bit, which shows that the output message queue holds data. A second mask, the service request enable, selects which status byte bits may raise the service request line. The request latches, and only a serial poll or a clear-status strobe releases it.

Responses reach the instrument's bus side through a small first-in first-out queue with valid/ready handshakes on both ends. A word is accepted on the write side only in a cycle where `push_valid` and `push_ready` are both high, and `push_ready` is low while the queue is full. A word leaves on the read side only in a cycle where `pop_valid` and `pop_ready` are both high, and `pop_data` holds steady until that happens. An operation-complete request stays armed until the interface is idle and the queue has drained. Only then is the operation-complete event bit set.

Top module: `status_report`

## Requirements
- R1: Event register bits are command error (bit 5, strobe `ev_cmd_err`), power-on (bit 7, strobe `ev_pwr_on`) and operation complete (bit 0). A strobe sets its bit on the next clock edge, and the bit stays set after the strobe drops.
- R2: `esr_rdata` always shows the event register. Pulsing `esr_rd` returns the current value in that cycle and clears the register on the next edge. Events strobed in the same cycle survive into the new value. With power-on and command error both set, the read returns 160.
- R3: Status byte bit 5 is the OR of (event register AND event enable mask). Writing either mask (`ese_wr`, `sre_wr`, value on `wr_data`) leaves the event bits untouched, and the summary bit follows the new mask immediately.
- R4: Status byte bit 4 is high exactly while the output queue holds at least one word.
- R5: The queue returns words in arrival order and holds up to DEPTH words. `push_ready` is low while the queue is full, and a push offered then is not stored.
- R6: The request condition is the OR of (status byte AND service request enable), with bit 6 of the enable ignored. A false-to-true change of the condition sets the request on the next edge. Status byte bit 6 and `srq` both show the request, and status byte bits 0–3 and 7 read zero.
- R7: `spoll` returns the status byte in the current cycle and clears the request on the next edge. The request stays low until the condition goes from false to true again. A poll taken on a request caused by the event summary alone reads 96.
- R8: A pulse on `opc_req` arms a pending request. On the first edge after arming where `bus_busy` is low and the queue is empty, event bit 0 is set and the request is disarmed.
- R9: `cls` empties the queue, clears the event register, the request and the pending operation-complete request, and keeps both masks. Events strobed in the same cycle are kept, and a push offered in that cycle is discarded.
- R10: After reset every register is zero, the queue is empty and `push_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_cmd_err | input | 1 | Unrecognized-command event strobe |
| ev_pwr_on | input | 1 | Power-on event strobe |
| opc_req | input | 1 | Operation-complete request strobe |
| bus_busy | input | 1 | High while the bus interface is active |
| ese_wr | input | 1 | Write event enable mask |
| sre_wr | input | 1 | Write service request enable mask |
| wr_data | input | 8 | Mask write value |
| esr_rd | input | 1 | Destructive event register read |
| cls | input | 1 | Clear-status strobe |
| spoll | input | 1 | Serial poll strobe |
| esr_rdata | output | 8 | Event register value |
| ese_rdata | output | 8 | Event enable mask |
| sre_rdata | output | 8 | Service request enable mask |
| stb_byte | output | 8 | Status byte / serial-poll response |
| srq | output | 1 | Service request line |
| push_valid | input | 1 | Queue write offer |
| push_ready | output | 1 | Queue can accept |
| push_data | input | DW | Queue write word |
| pop_valid | output | 1 | Queue has a word |
| pop_ready | input | 1 | Consumer takes the word |
| pop_data | output | DW | Oldest queued word |

## Verification
The bench builds the block with DEPTH = 4 and DW = 8. A shallow queue fills within a few pushes, so the full condition, refused pushes and a push and pop in the same cycle at the boundary all occur often under random stimulus. The same short drain times let operation-complete requests fire while strobes, polls and clear-status pulses overlap them. The eight-bit data width lets the bench use random words to check the ordering of the queue.

// File: rtl/status_report_pkg.sv
package status_report_pkg;
  localparam int EVB_OPC = 0;
  localparam int EVB_CME = 5;
  localparam int EVB_PON = 7;
  localparam int SBB_MAV = 4;
  localparam int SBB_ESB = 5;
  localparam int SBB_RQS = 6;
  localparam int REG_W   = 8;
endpackage

// File: rtl/evt_status_reg.sv
module evt_status_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] ev_set,
  input  logic         rd_clr,
  input  logic         clr,
  input  logic         mask_wr,
  input  logic [W-1:0] mask_data,
  output logic [W-1:0] ev_q,
  output logic [W-1:0] mask_q,
  output logic         summary
);
  // sticky bits: cleared only by a read or clear-status, new events always win
  always_ff @(posedge clk) begin
    if (!rst_n) ev_q <= '0;
    else        ev_q <= ((rd_clr || clr) ? '0 : ev_q) | ev_set;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_wr) mask_q <= mask_data;
  end

  assign summary = |(ev_q & mask_q);
endmodule

// File: rtl/out_queue.sv
module out_queue #(
  parameter int DW    = 8,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] rd_p, wr_p;
  logic [CW-1:0] cnt;
  logic          do_push, do_pop;

  assign in_ready  = (cnt != FULL);
  assign out_valid = (cnt != '0);
  assign out_data  = mem[rd_p];
  assign do_push   = in_valid && in_ready && !flush;
  assign do_pop    = out_valid && out_ready && !flush;

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      rd_p <= '0;
      wr_p <= '0;
      cnt  <= '0;
    end else begin
      if (do_push) wr_p <= (wr_p == LAST) ? '0 : wr_p + 1'b1;
      if (do_pop)  rd_p <= (rd_p == LAST) ? '0 : rd_p + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (do_push && wr_p == AW'(i)) mem[i] <= in_data;
    end
  end
endmodule

// File: rtl/svc_req_ctrl.sv
module svc_req_ctrl
  import status_report_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             esb,
  input  logic             mav,
  input  logic             sre_wr,
  input  logic [REG_W-1:0] wr_data,
  input  logic             spoll,
  input  logic             clr,
  output logic [REG_W-1:0] stb,
  output logic [REG_W-1:0] sre_q,
  output logic             srq
);
  logic rqs, cond, cond_q;

  always_comb begin
    stb          = '0;
    stb[SBB_MAV] = mav;
    stb[SBB_ESB] = esb;
    stb[SBB_RQS] = rqs;
  end

  // the request bit itself never feeds the condition
  assign cond = |(stb & sre_q & ~(REG_W'(1) << SBB_RQS));

  always_ff @(posedge clk) begin
    if (!rst_n)      sre_q <= '0;
    else if (sre_wr) sre_q <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rqs    <= 1'b0;
      cond_q <= 1'b0;
    end else begin
      cond_q <= cond;
      if (clr)                 rqs <= 1'b0;
      else if (cond && !cond_q) rqs <= 1'b1;
      else if (spoll)          rqs <= 1'b0;
    end
  end

  assign srq = rqs;
endmodule

// File: rtl/status_report.sv
module status_report
  import status_report_pkg::*;
#(
  parameter int DW    = 8,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ev_cmd_err,
  input  logic          ev_pwr_on,
  input  logic          opc_req,
  input  logic          bus_busy,
  input  logic          ese_wr,
  input  logic          sre_wr,
  input  logic [7:0]    wr_data,
  input  logic          esr_rd,
  input  logic          cls,
  input  logic          spoll,
  output logic [7:0]    esr_rdata,
  output logic [7:0]    ese_rdata,
  output logic [7:0]    sre_rdata,
  output logic [7:0]    stb_byte,
  output logic          srq,
  input  logic          push_valid,
  output logic          push_ready,
  input  logic [DW-1:0] push_data,
  output logic          pop_valid,
  input  logic          pop_ready,
  output logic [DW-1:0] pop_data
);
  logic             opc_armed, opc_fire, esb;
  logic [REG_W-1:0] ev_set;

  // pending operation-complete: waits for an idle bus and a drained queue
  assign opc_fire = opc_armed && !bus_busy && !pop_valid && !cls;

  always_ff @(posedge clk) begin
    if (!rst_n || cls)  opc_armed <= 1'b0;
    else if (opc_req)   opc_armed <= 1'b1;
    else if (opc_fire)  opc_armed <= 1'b0;
  end

  always_comb begin
    ev_set          = '0;
    ev_set[EVB_CME] = ev_cmd_err;
    ev_set[EVB_PON] = ev_pwr_on;
    ev_set[EVB_OPC] = opc_fire;
  end

  evt_status_reg #(.W(REG_W)) u_evt (
    .clk       (clk),
    .rst_n     (rst_n),
    .ev_set    (ev_set),
    .rd_clr    (esr_rd),
    .clr       (cls),
    .mask_wr   (ese_wr),
    .mask_data (wr_data),
    .ev_q      (esr_rdata),
    .mask_q    (ese_rdata),
    .summary   (esb)
  );

  out_queue #(.DW(DW), .DEPTH(DEPTH)) u_q (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (cls),
    .in_valid  (push_valid),
    .in_ready  (push_ready),
    .in_data   (push_data),
    .out_valid (pop_valid),
    .out_ready (pop_ready),
    .out_data  (pop_data)
  );

  svc_req_ctrl u_svc (
    .clk     (clk),
    .rst_n   (rst_n),
    .esb     (esb),
    .mav     (pop_valid),
    .sre_wr  (sre_wr),
    .wr_data (wr_data),
    .spoll   (spoll),
    .clr     (cls),
    .stb     (stb_byte),
    .sre_q   (sre_rdata),
    .srq     (srq)
  );
endmodule

// File: rtl/status_report_chk.sv
module status_report_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ev_cmd_err,
  input logic       ev_pwr_on,
  input logic       ese_wr,
  input logic       esr_rd,
  input logic       cls,
  input logic       spoll,
  input logic [7:0] esr_rdata,
  input logic [7:0] sre_rdata,
  input logic [7:0] stb_byte,
  input logic       srq,
  input logic       push_ready,
  input logic       pop_valid
);
  logic cond, cond_q, rise;
  assign cond = |(stb_byte & sre_rdata & 8'hBF);
  assign rise = cond && !cond_q;
  always_ff @(posedge clk) begin
    if (!rst_n) cond_q <= 1'b0;
    else        cond_q <= cond;
  end

  AST_CME_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (esr_rdata[5] && !esr_rd && !cls) |=> esr_rdata[5]); // R1
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (esr_rd && !ev_cmd_err && !ev_pwr_on) |=> (esr_rdata[7:1] == 7'd0)); // R2
  AST_MASK_KEEPS_EVENTS: assert property (@(posedge clk) disable iff (!rst_n)
    (ese_wr && !esr_rd && !cls) |=> ((esr_rdata & $past(esr_rdata)) == $past(esr_rdata))); // R3
  AST_MAV_TRACKS_QUEUE: assert property (@(posedge clk) disable iff (!rst_n)
    stb_byte[4] == pop_valid); // R4
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    !push_ready |-> pop_valid); // R5
  AST_POLL_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    (spoll && !rise) |=> !srq); // R7
  AST_CLS_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    cls |=> (!pop_valid && !srq)); // R9
endmodule

bind status_report status_report_chk u_chk (.*);

// File: tb/sim_status_report.sv
module sim_status_report;
  localparam int DW = 8;
  localparam int DEPTH = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ev_cmd_err = 0, ev_pwr_on = 0, opc_req = 0, bus_busy = 0;
  logic ese_wr = 0, sre_wr = 0, esr_rd = 0, cls = 0, spoll = 0;
  logic [7:0] wr_data = 0;
  logic push_valid = 0, pop_ready = 0;
  logic [DW-1:0] push_data = 0;
  logic [7:0] esr_rdata, ese_rdata, sre_rdata, stb_byte;
  logic srq, push_ready, pop_valid;
  logic [DW-1:0] pop_data;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  status_report #(.DW(DW), .DEPTH(DEPTH)) u0 (.*);

  // behavioural reference
  int m_esr, m_ese, m_sre, m_rqs, m_condq, m_arm;
  int q[$];

  function automatic int m_stb();
    return ((q.size() > 0) << 4) | (((m_esr & m_ese) != 0) << 5) | (m_rqs << 6);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_esr = 0; m_ese = 0; m_sre = 0; m_rqs = 0; m_condq = 0; m_arm = 0;
      q.delete();
    end else begin
      int stb, cond, fire, ev, n_rqs, n_arm;
      bit pushf, popf;
      stb = m_stb();
      cond = ((stb & m_sre & 'hBF) != 0);
      fire = m_arm && !bus_busy && q.size() == 0 && !cls;
      ev = (ev_cmd_err << 5) | (ev_pwr_on << 7) | fire;
      n_rqs = cls ? 0 : (cond && !m_condq) ? 1 : spoll ? 0 : m_rqs;
      n_arm = cls ? 0 : opc_req ? 1 : fire ? 0 : m_arm;
      pushf = push_valid && q.size() < DEPTH;
      popf = pop_ready && q.size() > 0;
      m_esr = ((esr_rd || cls) ? 0 : m_esr) | ev;
      if (ese_wr) m_ese = wr_data;
      if (sre_wr) m_sre = wr_data;
      m_rqs = n_rqs; m_condq = cond; m_arm = n_arm;
      if (cls) q.delete();
      else begin
        if (popf) void'(q.pop_front());
        if (pushf) q.push_back(int'(push_data));
      end
    end
  end

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("R1 event bits", int'(esr_rdata) & 'hFE, m_esr & 'hFE);
    chk("R8 opc bit", int'(esr_rdata[0]), m_esr & 1);
    chk("R3 ese mask", int'(ese_rdata), m_ese);
    chk("R6 sre mask", int'(sre_rdata), m_sre);
    chk("R3 R4 R6 status byte", int'(stb_byte), m_stb());
    chk("R6 srq", int'(srq), m_rqs);
    chk("R5 push_ready", int'(push_ready), int'(q.size() < DEPTH));
    chk("R4 pop_valid", int'(pop_valid), int'(q.size() > 0));
    if (q.size() > 0) chk("R5 order", int'(pop_data), q[0]);
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    compare_all();
    ev_cmd_err = 0; ev_pwr_on = 0; opc_req = 0; ese_wr = 0; sre_wr = 0;
    esr_rd = 0; cls = 0; spoll = 0; push_valid = 0; pop_ready = 0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R10 reset state
    chk("R10 esr", int'(esr_rdata), 0);
    chk("R10 stb", int'(stb_byte), 0);
    chk("R10 push_ready", int'(push_ready), 1);
    chk("R10 srq", int'(srq), 0);
    // R3 R6 R7: summary path to request, poll reads 96
    wr_data = 8'd32; ese_wr = 1; step();
    wr_data = 8'd32; sre_wr = 1; step();
    ev_cmd_err = 1; step();
    chk("R1 cme set", int'(esr_rdata), 32);
    step();
    chk("R6 srq raised", int'(srq), 1);
    chk("R7 poll byte 96", int'(stb_byte), 96);
    spoll = 1; step();
    chk("R7 srq cleared", int'(srq), 0);
    ev_cmd_err = 1; step(); step();
    chk("R7 no re-arm while condition holds", int'(srq), 0);
    // R2 power-on plus command error reads 160, then clears
    ev_pwr_on = 1; step();
    chk("R2 read 160", int'(esr_rdata), 160);
    esr_rd = 1; ev_cmd_err = 1; step();
    chk("R2 same-cycle event kept", int'(esr_rdata), 32);
    esr_rd = 1; step(); step();
    // R4 R5: queue fill and drain
    wr_data = 8'd16; sre_wr = 1; step();
    for (int i = 0; i < DEPTH + 2; i++) begin
      push_valid = 1; push_data = DW'(8'hA0 + i); step();
    end
    chk("R5 full", int'(push_ready), 0);
    chk("R4 mav", int'(stb_byte[4]), 1);
    // R8 opc waits for drain and idle
    opc_req = 1; bus_busy = 1; step();
    for (int i = 0; i < DEPTH; i++) begin pop_ready = 1; step(); end
    step();
    chk("R8 held while busy", int'(esr_rdata[0]), 0);
    bus_busy = 0; step(); step();
    chk("R8 opc set", int'(esr_rdata[0]), 1);
    // R9 clear-status keeps masks
    push_valid = 1; push_data = 8'h55; step();
    cls = 1; step();
    chk("R9 queue empty", int'(pop_valid), 0);
    chk("R9 mask kept", int'(sre_rdata), 16);
    // random phase
    for (int c = 0; c < 4000; c++) begin
      ev_cmd_err = ($urandom_range(15) == 0);
      ev_pwr_on  = ($urandom_range(63) == 0);
      opc_req    = ($urandom_range(31) == 0);
      bus_busy   = ($urandom_range(3) == 0);
      ese_wr     = ($urandom_range(31) == 0);
      sre_wr     = ($urandom_range(31) == 0);
      wr_data    = 8'($urandom);
      esr_rd     = ($urandom_range(15) == 0);
      cls        = ($urandom_range(127) == 0);
      spoll      = ($urandom_range(7) == 0);
      push_valid = ($urandom_range(2) == 0);
      push_data  = DW'($urandom);
      pop_ready  = ($urandom_range(2) == 0);
      step();
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule